// File: doc/BRIEF.md
# Two-Wire Serial Shift Interface

This peripheral is the hardware layer of a two-wire serial link. Software does the protocol work: addressing, acknowledge and arbitration. The block supplies the pieces that need exact timing. It has an 8-bit shift register that moves one bit per rising clock edge and a holding buffer that captures each completed byte. A 4-bit edge counter counts both clock edges, so one byte takes 16 counts. Two detectors watch for start and stop patterns on the bus, and a collision indicator reports when the line does not match what the block is driving. Software drives the clock line itself by writing a toggle bit.

Software reaches four byte-wide registers through a simple write-strobe and address port. Reads return the addressed register one cycle after the address is presented. Bus-side, the block drives the clock and data lines open-drain: a `*_drive_low` output of 1 pulls that line low. It samples both lines through a synchronizer.

Register map by address: 0 is the shift/data register (read/write), 1 is the receive buffer (read only), 2 is status and 3 is control.
- Status: bit 7 start seen, bit 6 counter wrapped, bit 5 stop seen, bit 4 collision (live, read only), bits 3:0 edge counter.
- Control: bit 7 start interrupt enable, bit 6 wrap interrupt enable, bits 5:4 line mode (2'b10 = two-wire), bits 3:2 count source (2'b10 = count clock toggles), bit 1 count strobe, bit 0 clock toggle. Bits 1:0 act only on the write that carries them and always read back as 0.

Top module: `tw_shift_if`

## Requirements
- R1: After reset: data reads 0xFF, buffer 0x00, status 0x00, control 0x00. Neither line is driven low and irq is 0.
- R2: A write to address 0 loads the data register and reads back unchanged. A write to address 1 changes nothing.
- R3: In two-wire mode, a control write with bit 0 = 1 inverts the internal clock output, and scl_drive_low follows its inverse. Control bits 1:0 always read back as 0.
- R4: The counter advances by exactly one on a toggle write only when that same write has bits 3:2 = 2'b10 and bit 1 = 1. Other toggles leave the counter unchanged.
- R5: On a counted toggle that takes the clock from 0 to 1, the data register shifts left and takes the synchronized SDA level into bit 0. The data MSB drives SDA open-drain, a 1 releasing the line. The MSB is loaded on a data write and follows the register while the clock output is low.
- R6: The counted toggle that moves the counter past 15 wraps it to 0, sets the wrap flag (status bit 6) and copies the shifted data byte into the buffer.
- R7: In two-wire mode, scl_drive_low stays 1 while the wrap flag is set and releases once software clears the flag.
- R8: A status write clears each of bits 7, 6 and 5 that it carries as 1 and leaves those written 0 untouched. It also loads the counter from bits 3:0.
- R9: A synchronized falling SDA while SCL is high sets status bit 7. A rising SDA while SCL is high sets status bit 5.
- R10: Status bit 4 reads 1 while the block releases SDA in two-wire mode but the sampled line is low.
- R11: irq is (bit 7 enable and start flag) or (bit 6 enable and wrap flag). The stop flag never raises irq.
- R12: With a mode other than 2'b10, both lines are released and toggle writes move neither the clock nor the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for the address of the previous cycle |
| scl_in | input | 1 | Sampled clock line level |
| sda_in | input | 1 | Sampled data line level |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sda_drive_low | output | 1 | 1 pulls the data line low |
| irq | output | 1 | Interrupt request |

## Verification
The bench models a wired-AND bus with a target that pulls chosen bits low. Bytes in which the target overrides some ones or all of them catch a design that shifts on the falling edge, samples its own output instead of the line, or copies the buffer before the final shift. The bench opens and closes a condition while SCL is high. A detector without the "SCL high" qualifier, or one that latches data changes made while the clock is low, would show spurious flags. Further checks clear one flag at a time with a one while others stay written as zero, and test the hold of SCL after the wrap. These catch a clear-on-any-write status and a clock line released too early. Toggles written without the count strobe, or in a non-two-wire mode, expose a counter that advances on every toggle or lines that stay driven when the mode is off.

// File: rtl/tw_shift_pkg.sv
package tw_shift_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_BUF  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam logic [1:0] MODE_TWO_WIRE = 2'b10;
  localparam logic [1:0] CSRC_TOGGLE   = 2'b10;

  // stored part of the control register (bits 7:2)
  typedef struct packed {
    logic       start_ie;
    logic       wrap_ie;
    logic [1:0] mode;
    logic [1:0] csrc;
  } ctrl_t;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/tw_bus_events.sv
module tw_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      start_ev <= 1'b0;
      stop_ev  <= 1'b0;
    end else begin
      scl_d    <= scl_s;
      sda_d    <= sda_s;
      // conditions only count while the clock is high on both samples
      start_ev <= scl_d & scl_s &  sda_d & ~sda_s;
      stop_ev  <= scl_d & scl_s & ~sda_d &  sda_s;
    end
  end

endmodule

// File: rtl/tw_shift_engine.sv
module tw_shift_engine #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rise,
  input  logic              sda_bit,
  input  logic              data_we,
  input  logic [DATA_W-1:0] data_wdata,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] buf_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              wrap
);

  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [DATA_W-1:0] data_nxt;

  always_comb begin
    data_nxt = data_q;
    if (data_we)   data_nxt = data_wdata;
    else if (rise) data_nxt = {data_q[DATA_W-2:0], sda_bit};
  end

  assign wrap = tick & ~cnt_we & (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '1;
      buf_q  <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_nxt;
      if (wrap) buf_q <= data_nxt;
      if (cnt_we)    cnt_q <= cnt_wdata;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tw_shift_if.sv
module tw_shift_if
  import tw_shift_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_drive_low,
  output logic              sda_drive_low,
  output logic              irq
);

  localparam int CNT_W  = $clog2(2 * DATA_W);
  localparam int STAT_W = 4 + CNT_W;

  // register decode
  logic  wr_data, wr_stat, wr_ctrl;
  ctrl_t wctrl, ctrl_q;
  logic  w_strobe, w_toggle;

  assign wr_data  = reg_we && (reg_addr == SEL_DATA);
  assign wr_stat  = reg_we && (reg_addr == SEL_STAT);
  assign wr_ctrl  = reg_we && (reg_addr == SEL_CTRL);
  assign wctrl    = ctrl_t'(reg_wdata[7:2]);
  assign w_strobe = reg_wdata[1];
  assign w_toggle = reg_wdata[0];

  // synchronized bus lines
  logic [1:0] lines_s;
  logic       scl_s, sda_s;

  tw_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({scl_in, sda_in}),
    .sync_out (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  logic start_ev, stop_ev;

  tw_bus_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  // software clock and count strobe
  logic scl_out, sda_out;
  logic tog_ev, tick, rise, wrap;
  logic mode2w;

  assign mode2w = (ctrl_q.mode == MODE_TWO_WIRE);
  assign tog_ev = wr_ctrl & w_toggle & (wctrl.mode == MODE_TWO_WIRE);
  assign tick   = tog_ev & w_strobe & (wctrl.csrc == CSRC_TOGGLE);
  assign rise   = tick & ~scl_out;

  logic [DATA_W-1:0] data_q, buf_q;
  logic [CNT_W-1:0]  cnt_q;

  tw_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_engine (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .rise       (rise),
    .sda_bit    (sda_s),
    .data_we    (wr_data),
    .data_wdata (reg_wdata),
    .cnt_we     (wr_stat),
    .cnt_wdata  (reg_wdata[CNT_W-1:0]),
    .data_q     (data_q),
    .buf_q      (buf_q),
    .cnt_q      (cnt_q),
    .wrap       (wrap)
  );

  // flags
  logic start_flag, wrap_flag, stop_flag, collision;

  assign collision = mode2w & sda_out & ~sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      scl_out    <= 1'b1;
      sda_out    <= 1'b1;
      start_flag <= 1'b0;
      wrap_flag  <= 1'b0;
      stop_flag  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wctrl;
      if (tog_ev)  scl_out <= ~scl_out;
      // data output changes only while the clock output is low
      if (wr_data)       sda_out <= reg_wdata[DATA_W-1];
      else if (!scl_out) sda_out <= data_q[DATA_W-1];
      start_flag <= start_ev | (start_flag & ~(wr_stat & reg_wdata[7]));
      wrap_flag  <= wrap     | (wrap_flag  & ~(wr_stat & reg_wdata[6]));
      stop_flag  <= stop_ev  | (stop_flag  & ~(wr_stat & reg_wdata[5]));
    end
  end

  // registered outputs
  logic [STAT_W-1:0] stat_word;
  assign stat_word = {start_flag, wrap_flag, stop_flag, collision, cnt_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata     <= '0;
      scl_drive_low <= 1'b0;
      sda_drive_low <= 1'b0;
      irq           <= 1'b0;
    end else begin
      unique case (reg_sel_e'(reg_addr))
        SEL_DATA: reg_rdata <= data_q;
        SEL_BUF:  reg_rdata <= buf_q;
        SEL_STAT: reg_rdata <= DATA_W'(stat_word);
        SEL_CTRL: reg_rdata <= DATA_W'({ctrl_q, 2'b00});
        default:  reg_rdata <= '0;
      endcase
      scl_drive_low <= mode2w & (~scl_out | wrap_flag);
      sda_drive_low <= mode2w & ~sda_out;
      irq           <= (ctrl_q.start_ie & start_flag) | (ctrl_q.wrap_ie & wrap_flag);
    end
  end

endmodule

// File: rtl/tw_shift_if_chk.sv
module tw_shift_if_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             w_wrap_clr,
  input logic [1:0]       w_mode,
  input logic             w_toggle,
  input logic             scl_drive_low,
  input logic             sda_drive_low,
  input logic             irq,
  input logic             wrap_flag,
  input logic             start_flag,
  input logic [CNT_W-1:0] cnt_q,
  input logic             mode2w,
  input logic             scl_out,
  input logic             tick
);

  logic stat_wr, tog_wr;
  assign stat_wr = reg_we && (reg_addr == 2'd2);
  assign tog_wr  = reg_we && (reg_addr == 2'd3) && w_toggle && (w_mode == 2'b10);

  // R7
  scl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode2w && wrap_flag) |=> scl_drive_low);

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    !mode2w |=> (!scl_drive_low && !sda_drive_low));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_flag && !wrap_flag) |=> !irq);

  // R6
  wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt_q == '1) && !stat_wr) |=> wrap_flag);

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_wr && !tick) |=> $stable(cnt_q));

  // R3
  toggle_chk: assert property (@(posedge clk) disable iff (rst)
    tog_wr |=> (scl_out != $past(scl_out)));

  // R8
  w1c_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap_flag && !(stat_wr && w_wrap_clr)) |=> wrap_flag);

endmodule

bind tw_shift_if tw_shift_if_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .w_wrap_clr    (reg_wdata[6]),
  .w_mode        (reg_wdata[5:4]),
  .w_toggle      (reg_wdata[0]),
  .scl_drive_low (scl_drive_low),
  .sda_drive_low (sda_drive_low),
  .irq           (irq),
  .wrap_flag     (wrap_flag),
  .start_flag    (start_flag),
  .cnt_q         (cnt_q),
  .mode2w        (mode2w),
  .scl_out       (scl_out),
  .tick          (tick)
);

// File: tb/tw_shift_if_bench.sv
module tw_shift_if_bench;

  localparam logic [1:0] A_DATA = 2'd0, A_BUF = 2'd1, A_STAT = 2'd2, A_CTRL = 2'd3;
  localparam int NVEC = 6;
  // {tx byte, target pull-low mask (bit-aligned), expected received byte}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hA5, 8'h00, 8'hA5},
    {8'hFF, 8'h3C, 8'hC3},
    {8'h00, 8'hFF, 8'h00},
    {8'h96, 8'h0F, 8'h90},
    {8'h5A, 8'h81, 8'h5A},
    {8'hC3, 8'hFF, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       scl_drive_low, sda_drive_low, irq;
  logic       ext_sda_low = 1'b0;
  logic       scl_line, sda_line;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  assign scl_line = ~scl_drive_low;
  assign sda_line = ~(sda_drive_low | ext_sda_low);

  tw_shift_if u_tw_shift_if (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .scl_in        (scl_line),
    .sda_in        (sda_line),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .irq           (irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] tx, input logic [7:0] mask);
    wr(A_DATA, tx);
    idle(6);
    wr(A_STAT, 8'hF0);
    idle(4);
    for (int k = 0; k < 16; k++) begin
      wr(A_CTRL, 8'h2B);
      idle(4);
      if ((k % 2) == 0) begin
        ext_sda_low = mask[7 - k / 2];
        idle(4);
      end
    end
    ext_sda_low = 1'b0;
    idle(6);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(A_DATA, v); check("R1 data", v, 8'hFF);
    rd(A_BUF,  v); check("R1 buffer", v, 8'h00);
    rd(A_STAT, v); check("R1 status", v, 8'h00);
    rd(A_CTRL, v); check("R1 control", v, 8'h00);
    check("R1 scl drive", {7'd0, scl_drive_low}, 8'h00);
    check("R1 sda drive", {7'd0, sda_drive_low}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 data write, buffer write ignored
    wr(A_DATA, 8'h5A);
    rd(A_DATA, v); check("R2 data readback", v, 8'h5A);
    wr(A_BUF, 8'h12);
    rd(A_BUF, v); check("R2 buffer not writable", v, 8'h00);

    wr(A_CTRL, 8'h28);
    idle(4);

    // R5 R6 R7 byte transfers over the modelled bus
    for (int i = 0; i < NVEC; i++) begin
      send_byte(VEC[i][23:16], VEC[i][15:8]);
      rd(A_BUF, v);  check("R6 buffer byte", v, VEC[i][7:0]);
      rd(A_DATA, v); check("R5 shifted data", v, VEC[i][7:0]);
      rd(A_STAT, v); check("R6 wrap flag, counter zero", v, 8'h40);
      check("R7 scl held after wrap", {7'd0, scl_drive_low}, 8'h01);
    end

    // R11 wrap interrupt
    wr(A_CTRL, 8'h68);
    idle(3);
    check("R11 wrap irq", {7'd0, irq}, 8'h01);

    // R7 release after clearing the flag
    wr(A_DATA, 8'hFF);
    wr(A_CTRL, 8'h28);
    idle(3);
    check("R11 irq off without enable", {7'd0, irq}, 8'h00);
    wr(A_STAT, 8'hF0);
    idle(3);
    check("R7 scl released", {7'd0, scl_drive_low}, 8'h00);
    rd(A_STAT, v); check("R8 all cleared", v, 8'h00);

    // R9 R10 start and collision
    idle(4);
    ext_sda_low = 1'b1;
    idle(8);
    rd(A_STAT, v); check("R9 R10 start and collision", v, 8'h90);
    check("R11 start irq disabled", {7'd0, irq}, 8'h00);
    wr(A_CTRL, 8'hA8);
    idle(3);
    check("R11 start irq", {7'd0, irq}, 8'h01);
    wr(A_STAT, 8'h80);
    idle(3);
    rd(A_STAT, v); check("R8 start cleared alone", v, 8'h10);
    check("R11 irq drops", {7'd0, irq}, 8'h00);
    ext_sda_low = 1'b0;
    idle(8);
    rd(A_STAT, v); check("R9 stop flag", v, 8'h20);
    check("R11 stop raises no irq", {7'd0, irq}, 8'h00);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check("R8 zero write keeps flag", v, 8'h20);
    wr(A_STAT, 8'h25);
    rd(A_STAT, v); check("R8 clear and counter load", v, 8'h05);

    // R3 R4 uncounted toggles
    wr(A_CTRL, 8'h21);
    idle(3);
    check("R3 toggle drives scl low", {7'd0, scl_drive_low}, 8'h01);
    rd(A_STAT, v); check("R4 uncounted toggle", v, 8'h05);
    wr(A_CTRL, 8'h21);
    idle(3);
    check("R3 toggle releases scl", {7'd0, scl_drive_low}, 8'h00);
    wr(A_CTRL, 8'h2B);
    idle(3);
    rd(A_STAT, v); check("R4 counted toggle", v, 8'h06);
    rd(A_CTRL, v); check("R3 strobe bits read zero", v, 8'h28);

    // R5 MSB drives SDA
    wr(A_DATA, 8'h00);
    idle(3);
    check("R5 msb pulls sda", {7'd0, sda_drive_low}, 8'h01);

    // R12 other mode
    wr(A_CTRL, 8'h0B);
    idle(3);
    check("R12 scl released", {7'd0, scl_drive_low}, 8'h00);
    check("R12 sda released", {7'd0, sda_drive_low}, 8'h00);
    rd(A_STAT, v); check("R12 counter frozen", v & 8'h0F, 8'h06);
    rd(A_CTRL, v); check("R12 control readback", v, 8'h08);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule